// File: doc/BRIEF.md
# Tri-Mode Compensator Mode Arbiter

This block chooses which of two compensators drives the duty word of a digitally controlled buck converter, one step per control clock (one switching period). A PID law and an RST law run beside it. The arbiter runs the PID at a quarter of the control rate while the supply idles. It hands control to the RST law while the load is changing. It runs the PID at full rate once the output has settled. Two inputs decide when to leave a mode: the magnitude of the signed error word, compared against a threshold, and an external activity flag.

Each handover has an overlap window of programmable length. In that window both compensators are enabled, so the incoming law builds up its history while the outgoing law still drives the output mux. Each transient mode also has a minimum dwell, set in periods by a tuning input. Dwell and overlap share one down-counter, which is loaded on entry to each state that is counted.

Top module: `triModeArbiter`

## Requirements
- R1: After reset the outputs show standby: PID enabled, RST disabled, quarter-rate select high, and mux select 0. Mux select 0 means the PID drives and 1 means the RST drives.
- R2: At quarter rate, the PID update strobe pulses on every fourth control clock, counted from reset release. At full rate it is high on every clock while the PID is enabled.
- R3: Standby leaves for the entry overlap when the error magnitude is strictly above the threshold, or when the activity input is 1. A magnitude equal to the threshold does not trigger the exit.
- R4: The error word is two's complement, and its absolute value is compared. A negative error beyond the threshold triggers an exit, and so does the most negative code.
- R5: The overlap into the first transient lasts ovlpLen+1 clocks. During it both enables are high, the mux stays 0, and the PID stays at quarter rate.
- R6: The first transient (RST only, mux 1) lasts at least tune1+1 clocks. It ends at the first clock after that minimum where the error magnitude is strictly below the threshold.
- R7: The overlap from the first transient into steady state lasts ovlpLen+1 clocks. During it both enables are high, the mux stays 1, and the PID runs at full rate.
- R8: In steady state only the full-rate PID is enabled, with mux 0. Steady state is left for an overlap (both enabled, mux 0) when the error magnitude is above the threshold or the activity input is 0.
- R9: The second transient behaves like the first, but its minimum length is tune2+1 clocks.
- R10: After the second transient comes an overlap of ovlpLen+1 clocks, with the full-rate PID and mux 1. The arbiter then returns to standby.
- R11: The mux never selects a compensator that was not enabled on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, one tick per switching period |
| rstN | input | 1 | Active-low asynchronous reset |
| errIn | input | ERR_W | Signed error word |
| errThresh | input | ERR_W | Unsigned error magnitude threshold |
| actM | input | 1 | External activity flag |
| tune1 | input | TUNE_W | Minimum extra dwell of first transient, in periods |
| tune2 | input | TUNE_W | Minimum extra dwell of second transient, in periods |
| ovlpLen | input | OVL_W | Overlap window length minus one, in periods |
| pidEn | output | 1 | PID compensator enable |
| rstEn | output | 1 | RST compensator enable |
| pidQuarter | output | 1 | 1 = PID at quarter rate |
| pidStrobe | output | 1 | PID update strobe |
| muxRst | output | 1 | Output mux select, 1 = RST drives |

## Verification
The end of the minimum dwell and the error check can land on the same clock. The bench provokes this by keeping the error above the threshold exactly on the clock where the dwell counter reaches zero. It then checks that the transient continues, and that the handover starts one clock later, once the error has fallen below the threshold. Trigger values are driven exactly at the threshold and one step beyond it in both signs, and every state's length is checked clock by clock against the tuning and overlap inputs.

// File: rtl/tmArbPkg.sv
package tmArbPkg;
  typedef enum logic [2:0] {
    ST_SBY, ST_PRE1, ST_TR1, ST_POST1, ST_STEADY, ST_PRE2, ST_TR2, ST_POST2
  } arbState_e;

  typedef struct packed {
    logic loadTune1;
    logic loadTune2;
    logic loadOvl;
  } arbStrobe_t;

  typedef struct packed {
    logic errAbove;
    logic errBelow;
    logic cntZero;
    logic quarterTick;
  } arbFlags_t;
endpackage

// File: rtl/arbDatapath.sv
module arbDatapath
  import tmArbPkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int TUNE_W = 8,
  parameter int OVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ERR_W-1:0]  errIn,
  input  logic [ERR_W-1:0]  errThresh,
  input  logic [TUNE_W-1:0] tune1,
  input  logic [TUNE_W-1:0] tune2,
  input  logic [OVL_W-1:0]  ovlpLen,
  input  arbStrobe_t        strobe,
  output arbFlags_t         flags
);
  localparam int CNT_W = (TUNE_W > OVL_W) ? TUNE_W : OVL_W;

  logic [ERR_W-1:0] errMag;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       divCnt;

  always_comb begin
    errMag = errIn[ERR_W-1] ? (~errIn + 1'b1) : errIn;
    flags.errAbove    = errMag > errThresh;
    flags.errBelow    = errMag < errThresh;
    flags.cntZero     = (cnt == '0);
    flags.quarterTick = (divCnt == 2'd3);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadTune1) begin
      cnt <= CNT_W'(tune1);
    end else if (strobe.loadTune2) begin
      cnt <= CNT_W'(tune2);
    end else if (strobe.loadOvl) begin
      cnt <= CNT_W'(ovlpLen);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  // R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0 && !strobe.loadTune1 && !strobe.loadTune2 && !strobe.loadOvl) |=> cnt == '0);

  // R2
  quarter_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.quarterTick |=> !flags.quarterTick);
endmodule

// File: rtl/arbControl.sv
module arbControl
  import tmArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actM,
  input  arbFlags_t  flags,
  output arbStrobe_t strobe,
  output logic       pidEn,
  output logic       rstEn,
  output logic       pidQuarter,
  output logic       pidStrobe,
  output logic       muxRst
);
  arbState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_SBY:    if (flags.errAbove || actM)                stateNext = ST_PRE1;
      ST_PRE1:   if (flags.cntZero)                         stateNext = ST_TR1;
      ST_TR1:    if (flags.cntZero && flags.errBelow)       stateNext = ST_POST1;
      ST_POST1:  if (flags.cntZero)                         stateNext = ST_STEADY;
      ST_STEADY: if (flags.errAbove || !actM)               stateNext = ST_PRE2;
      ST_PRE2:   if (flags.cntZero)                         stateNext = ST_TR2;
      ST_TR2:    if (flags.cntZero && flags.errBelow)       stateNext = ST_POST2;
      ST_POST2:  if (flags.cntZero)                         stateNext = ST_SBY;
      default:                                              stateNext = ST_SBY;
    endcase
  end

  always_comb begin
    strobe = '0;
    if (stateNext != state) begin
      strobe.loadTune1 = (stateNext == ST_TR1);
      strobe.loadTune2 = (stateNext == ST_TR2);
      strobe.loadOvl   = (stateNext == ST_PRE1) || (stateNext == ST_POST1) ||
                         (stateNext == ST_PRE2) || (stateNext == ST_POST2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SBY;
    else       state <= stateNext;
  end

  always_comb begin
    pidEn = 1'b0; rstEn = 1'b0; pidQuarter = 1'b0; muxRst = 1'b0;
    case (state)
      ST_SBY:    begin pidEn = 1'b1; pidQuarter = 1'b1; end
      ST_PRE1:   begin pidEn = 1'b1; rstEn = 1'b1; pidQuarter = 1'b1; end
      ST_TR1,
      ST_TR2:    begin rstEn = 1'b1; muxRst = 1'b1; end
      ST_POST1,
      ST_POST2:  begin pidEn = 1'b1; rstEn = 1'b1; muxRst = 1'b1; end
      ST_STEADY: begin pidEn = 1'b1; end
      ST_PRE2:   begin pidEn = 1'b1; rstEn = 1'b1; end
      default:   begin pidEn = 1'b1; pidQuarter = 1'b1; end
    endcase
    pidStrobe = pidEn && (!pidQuarter || flags.quarterTick);
  end

  // R11
  mux_handover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (muxRst != $past(muxRst)) |-> $past(pidEn && rstEn));

  // R5
  rst_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstEn) |-> !muxRst);

  // R3
  standby_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_SBY) && state != ST_SBY) |-> $past(flags.errAbove || actM));

  // R6
  dwell_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state == ST_TR1) && state != ST_TR1) |-> $past(flags.cntZero && flags.errBelow));
endmodule

// File: rtl/triModeArbiter.sv
module triModeArbiter
  import tmArbPkg::*;
#(
  parameter int ERR_W  = 12,
  parameter int TUNE_W = 8,
  parameter int OVL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ERR_W-1:0]  errIn,
  input  logic [ERR_W-1:0]  errThresh,
  input  logic              actM,
  input  logic [TUNE_W-1:0] tune1,
  input  logic [TUNE_W-1:0] tune2,
  input  logic [OVL_W-1:0]  ovlpLen,
  output logic              pidEn,
  output logic              rstEn,
  output logic              pidQuarter,
  output logic              pidStrobe,
  output logic              muxRst
);
  arbStrobe_t strobe;
  arbFlags_t  flags;

  arbDatapath #(.ERR_W(ERR_W), .TUNE_W(TUNE_W), .OVL_W(OVL_W)) uDp (
    .clk(clk), .rstN(rstN), .errIn(errIn), .errThresh(errThresh),
    .tune1(tune1), .tune2(tune2), .ovlpLen(ovlpLen),
    .strobe(strobe), .flags(flags)
  );

  arbControl uCtl (
    .clk(clk), .rstN(rstN), .actM(actM), .flags(flags), .strobe(strobe),
    .pidEn(pidEn), .rstEn(rstEn), .pidQuarter(pidQuarter),
    .pidStrobe(pidStrobe), .muxRst(muxRst)
  );
endmodule

// File: tb/sim_triModeArbiter.sv
module sim_triModeArbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 34;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] errIn = '0;
  logic [11:0] errThresh = 12'd100;
  logic actM = 1'b0;
  logic [7:0] tune1 = 8'd3;
  logic [7:0] tune2 = 8'd5;
  logic [3:0] ovlpLen = 4'd2;
  logic pidEn, rstEn, pidQuarter, pidStrobe, muxRst;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  triModeArbiter u0 (
    .clk(clk), .rstN(rstN), .errIn(errIn), .errThresh(errThresh), .actM(actM),
    .tune1(tune1), .tune2(tune2), .ovlpLen(ovlpLen),
    .pidEn(pidEn), .rstEn(rstEn), .pidQuarter(pidQuarter),
    .pidStrobe(pidStrobe), .muxRst(muxRst)
  );

  // vector: {err[11:0], m, expected {pidEn,rstEn,pidQuarter,muxRst}}
  // SB=1010 PRE1=1110 TR=0101 POST=1101 SS=1000 PRE2=1100
  localparam logic [16:0] VEC [NVEC] = '{
    {12'sd0,    1'b0, 4'b1010},  // 0  R1 standby holds
    {12'sd100,  1'b0, 4'b1010},  // 1  R3 equal: no exit
    {-12'sd100, 1'b0, 4'b1010},  // 2  R4 negative equal: no exit
    {-12'sd101, 1'b0, 4'b1110},  // 3  R4 negative beyond -> overlap
    {12'sd0,    1'b1, 4'b1110},  // 4  R5
    {12'sd0,    1'b1, 4'b1110},  // 5  R5 (ovlpLen+1 = 3)
    {12'sd0,    1'b1, 4'b0101},  // 6  R6 transient 1
    {12'sd0,    1'b1, 4'b0101},  // 7
    {12'sd0,    1'b1, 4'b0101},  // 8
    {12'sd0,    1'b1, 4'b0101},  // 9  R6 tune1+1 = 4
    {12'sd150,  1'b1, 4'b0101},  // 10 R6 error high at dwell end: stays
    {-12'sd99,  1'b1, 4'b1101},  // 11 R7 post overlap
    {12'sd0,    1'b1, 4'b1101},  // 12
    {12'sd0,    1'b1, 4'b1101},  // 13
    {12'sd0,    1'b1, 4'b1000},  // 14 R8 steady
    {12'sd100,  1'b1, 4'b1000},  // 15 R8 equal: stays
    {-12'sd100, 1'b1, 4'b1000},  // 16
    {12'sd0,    1'b0, 4'b1100},  // 17 R8 m=0 -> overlap
    {12'sd0,    1'b0, 4'b1100},  // 18
    {12'sd0,    1'b0, 4'b1100},  // 19
    {12'sd0,    1'b0, 4'b0101},  // 20 R9 transient 2
    {12'sd0,    1'b0, 4'b0101},  // 21
    {12'sd0,    1'b0, 4'b0101},  // 22
    {12'sd0,    1'b0, 4'b0101},  // 23
    {12'sd0,    1'b0, 4'b0101},  // 24
    {12'sd0,    1'b0, 4'b0101},  // 25 R9 tune2+1 = 6
    {12'sd0,    1'b0, 4'b1101},  // 26 R10 full-rate overlap
    {12'sd0,    1'b0, 4'b1101},  // 27
    {12'sd0,    1'b0, 4'b1101},  // 28
    {12'sd0,    1'b0, 4'b1010},  // 29 R10 back to standby
    {12'sd0,    1'b0, 4'b1010},  // 30
    {12'sd0,    1'b1, 4'b1110},  // 31 R3 m=1 exit
    {12'sd0,    1'b1, 4'b1110},  // 32
    {12'sd0,    1'b1, 4'b1110}   // 33
  };

  task automatic chkCode(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {pidEn, rstEn, pidQuarter, muxRst};
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkNum(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; errIn = '0; actM = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    int strobes;
    doReset();
    chkCode("R1 reset", 4'b1010);
    for (int i = 0; i < NVEC; i++) begin
      errIn = VEC[i][16:5];
      actM  = VEC[i][4];
      @(negedge clk);
      chkCode($sformatf("vector %0d", i), VEC[i][3:0]);
    end

    // R1 and R2: reset, then quarter-rate strobes
    doReset();
    chkCode("R1 reset again", 4'b1010);
    strobes = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (pidStrobe) strobes++;
    end
    chkNum("R2 quarter-rate strobes in 16 clocks", strobes, 4);

    // R8 and R2: reach steady state, full-rate strobes
    actM = 1'b1;
    repeat (11) @(negedge clk);
    chkCode("R8 steady reached", 4'b1000);
    strobes = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pidStrobe) strobes++;
    end
    chkNum("R2 full-rate strobes in 6 clocks", strobes, 6);

    // R4: most negative code leaves steady state
    errIn = 12'h800;
    @(negedge clk);
    chkCode("R4 most negative error", 4'b1100);

    // R6: tune1 = 0 gives a one-clock transient
    tune1 = 8'd0;
    doReset();
    actM = 1'b1;
    repeat (4) @(negedge clk);
    chkCode("R6 tune1=0 transient", 4'b0101);
    @(negedge clk);
    chkCode("R7 post overlap after tune1=0", 4'b1101);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule